// File: doc/BRIEF.md
# Two-Level Lookahead Adder-Subtractor

This block adds or subtracts two 16-bit two's complement or unsigned operands in one combinational pass. The datapath is split into four 4-bit slices. Each slice expands its internal carries fully from per-bit generate and propagate terms. Each slice also reports a group generate and a group propagate. A second lookahead level turns those group terms and the incoming carry into the carry entering every slice and the final carry-out. No carry ripples from slice to slice.

A single mode input selects the operation. In subtract mode the second operand is inverted bit by bit and the carry into bit zero is forced high, so the result is the first operand minus the second. A signed overflow flag compares the sign of the result with the signs of the operands that the adder actually sees. The block has no clock and no state. It is meant to sit inside an execution datapath, with registers on either side.

Top module: `la_addsub16`

## Requirements
- R1: With `sub_mode`=0, `{carry_out, sum_out}` equals `op_a + op_b + carry_in`, with both operands taken as unsigned 16-bit values and the result as a 17-bit value.
- R2: With `sub_mode`=1, `{carry_out, sum_out}` equals `op_a + ~op_b + 1` as a 17-bit value. `sum_out` is therefore `op_a - op_b` modulo 2^16, and `carry_out` is 1 exactly when `op_a >= op_b` unsigned. `carry_in` has no effect on either output in this mode.
- R3: With `sub_mode`=0, `ovf` is 1 exactly when `op_a[15]` equals `op_b[15]` and `sum_out[15]` differs from them. When the operand signs differ, `ovf` is always 0.
- R4: With `sub_mode`=1, `ovf` is 1 exactly when `op_a[15]` differs from `op_b[15]` and `sum_out[15]` differs from `op_a[15]`. The test uses the inverted second operand, not the raw input.
- R5: A carry entering bit 0 travels across all four slices when every bit propagates. For example, `op_a`=16'hFFFF, `op_b`=0, `carry_in`=1 in add mode gives `sum_out`=0 and `carry_out`=1. A carry generated in any slice reaches every higher slice in the same way.
- R6: The outputs depend only on the present inputs. With all inputs at 0, every output reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand, inverted internally when subtracting |
| carry_in | input | 1 | Carry into bit 0 in add mode; ignored when subtracting |
| sub_mode | input | 1 | 0 selects add, 1 selects subtract |
| sum_out | output | 16 | Result bits |
| carry_out | output | 1 | Carry out of bit 15 |
| ovf | output | 1 | Signed overflow of the result |

## Verification
The block holds no state, so a wrong group term or slice carry appears on `sum_out` and `carry_out` for the same input vector. It only appears when that vector makes the faulty slice boundary carry. For this reason the directed cases place long propagate chains and single generates at each slice boundary. Random operands then cover general mixtures. A fault in inverting the second operand, or in the overflow test, appears immediately in subtract mode with mixed-sign operands, the most negative value and all ones.

// File: rtl/la_addsub16.sv
module la_addsub16 #(
  parameter int NBLK = 4,
  localparam int W = 4 * NBLK
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  input  logic         sub_mode,
  output logic [W-1:0] sum_out,
  output logic         carry_out,
  output logic         ovf
);

  logic [W-1:0]    b_eff, g, p;
  logic [W:0]      c;
  logic [NBLK-1:0] grp_g, grp_p;
  logic [NBLK:0]   blk_c;
  logic            c0;

  assign b_eff = op_b ^ {W{sub_mode}};
  assign c0    = sub_mode | carry_in;
  assign g     = op_a & b_eff;
  assign p     = op_a ^ b_eff;

  for (genvar k = 0; k < NBLK; k++) begin : g_slice
    logic [3:0] gi, pi;
    logic       ci;
    assign gi = g[4*k +: 4];
    assign pi = p[4*k +: 4];
    assign ci = blk_c[k];

    assign c[4*k]   = ci;
    assign c[4*k+1] = gi[0] | (pi[0] & ci);
    assign c[4*k+2] = gi[1] | (pi[1] & gi[0]) | (pi[1] & pi[0] & ci);
    assign c[4*k+3] = gi[2] | (pi[2] & gi[1]) | (pi[2] & pi[1] & gi[0])
                    | (pi[2] & pi[1] & pi[0] & ci);

    assign grp_p[k] = &pi;
    assign grp_g[k] = gi[3] | (pi[3] & gi[2]) | (pi[3] & pi[2] & gi[1])
                    | (pi[3] & pi[2] & pi[1] & gi[0]);
  end

  always_comb begin
    blk_c[0] = c0;
    for (int k = 0; k < NBLK; k++) begin
      logic acc, term;
      term = c0;
      for (int m = 0; m <= k; m++) term = term & grp_p[m];
      acc = term;
      for (int j = 0; j <= k; j++) begin
        term = grp_g[j];
        for (int m = j + 1; m <= k; m++) term = term & grp_p[m];
        acc = acc | term;
      end
      blk_c[k+1] = acc;
    end
  end

  assign c[W]      = blk_c[NBLK];
  assign sum_out   = p ^ c[W-1:0];
  assign carry_out = c[W];
  assign ovf       = (op_a[W-1] ~^ b_eff[W-1]) & (sum_out[W-1] ^ op_a[W-1]);

endmodule

module la_addsub16_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         carry_in,
  input logic         sub_mode,
  input logic [W-1:0] sum_out,
  input logic         carry_out,
  input logic         ovf
);
  logic [W:0] ref_add, ref_sub;
  logic       known;

  assign known   = !$isunknown({op_a, op_b, carry_in, sub_mode});
  assign ref_add = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};
  assign ref_sub = {1'b0, op_a} + {1'b0, ~op_b} + {{W{1'b0}}, 1'b1};

  always_comb begin
    if (known) begin
      if (!sub_mode)
        assert_add_result_R1: assert ({carry_out, sum_out} == ref_add);
      if (sub_mode)
        assert_sub_result_R2: assert ({carry_out, sum_out} == ref_sub);
      if (!sub_mode && (op_a[W-1] != op_b[W-1]))
        assert_no_overflow_R3: assert (!ovf);
      if (sub_mode && (op_a[W-1] == op_b[W-1]))
        assert_no_overflow_R4: assert (!ovf);
      if (!sub_mode && ((op_a ^ op_b) == {W{1'b1}}))
        assert_chain_R5: assert ((sum_out == {W{~carry_in}}) && (carry_out == carry_in));
    end
  end
endmodule

bind la_addsub16 la_addsub16_chk #(.W(W)) chk_i (
  .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .sub_mode(sub_mode),
  .sum_out(sum_out), .carry_out(carry_out), .ovf(ovf)
);

// File: tb/la_addsub16_tb.sv
module la_addsub16_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic        carry_in = 1'b0, sub_mode = 1'b0;
  logic [15:0] sum_out;
  logic        carry_out, ovf;
  int          n_vec = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  la_addsub16 dut_i (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .sub_mode(sub_mode),
    .sum_out(sum_out), .carry_out(carry_out), .ovf(ovf)
  );

  task automatic apply(input logic [15:0] a, input logic [15:0] b,
                       input logic ci, input logic sm, input string tag);
    logic [16:0] exp_r;
    logic [15:0] eb;
    logic        exp_v;
    @(negedge clk);
    op_a = a; op_b = b; carry_in = ci; sub_mode = sm;
    #(CLK_PERIOD/4);
    eb    = sm ? ~b : b;
    exp_r = {1'b0, a} + {1'b0, eb} + 17'(sm ? 1'b1 : ci);
    exp_v = (a[15] == eb[15]) && (exp_r[15] != a[15]);
    n_vec++;
    if ({carry_out, sum_out} !== exp_r || ovf !== exp_v) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h ci=%b sub=%b: got c=%b s=%h v=%b, exp c=%b s=%h v=%b",
               tag, a, b, ci, sm, carry_out, sum_out, ovf, exp_r[16], exp_r[15:0], exp_v);
    end
  endtask

  task automatic t_idle_R6;
    apply(16'h0000, 16'h0000, 1'b0, 1'b0, "R6 all-zero inputs");
  endtask

  task automatic t_add_R1;
    apply(16'h1234, 16'h4321, 1'b0, 1'b0, "R1 add");
    apply(16'h00FF, 16'h0001, 1'b1, 1'b0, "R1 add with carry_in");
    apply(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, "R1 all ones");
    apply(16'h8000, 16'h8000, 1'b0, 1'b0, "R1 most negative twice");
  endtask

  task automatic t_sub_R2;
    apply(16'h5000, 16'h1234, 1'b0, 1'b1, "R2 sub");
    apply(16'h5000, 16'h1234, 1'b1, 1'b1, "R2 sub carry_in ignored");
    apply(16'h0000, 16'h0001, 1'b0, 1'b1, "R2 borrow");
    apply(16'h1234, 16'h1234, 1'b1, 1'b1, "R2 equal");
    apply(16'h8000, 16'hFFFF, 1'b0, 1'b1, "R2 min minus -1");
  endtask

  task automatic t_ovf_R3_R4;
    apply(16'h7FFF, 16'h0001, 1'b0, 1'b0, "R3 positive overflow");
    apply(16'h8000, 16'hFFFF, 1'b0, 1'b0, "R3 negative overflow");
    apply(16'h7FFF, 16'h8000, 1'b1, 1'b0, "R3 mixed signs");
    apply(16'h8000, 16'h0001, 1'b0, 1'b1, "R4 min minus one");
    apply(16'h7FFF, 16'hFFFF, 1'b0, 1'b1, "R4 max minus -1");
    apply(16'h0000, 16'h8000, 1'b0, 1'b1, "R4 zero minus min");
    apply(16'hFFFF, 16'hFFFF, 1'b0, 1'b1, "R4 same sign no ovf");
  endtask

  task automatic t_chain_R5;
    apply(16'hFFFF, 16'h0000, 1'b1, 1'b0, "R5 full propagate");
    apply(16'hAAAA, 16'h5555, 1'b1, 1'b0, "R5 mixed propagate");
    for (int k = 0; k < 4; k++) begin
      apply(16'hFFFF >> (4*k), 16'h0001 << (4*k), 1'b0, 1'b0, "R5 generate at slice");
      apply(16'h000F << (4*k), 16'h0001 << (4*k), 1'b0, 1'b0, "R5 slice carry out");
    end
  endtask

  task automatic t_random_R1_R2;
    for (int i = 0; i < 2000; i++)
      apply(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), "R1/R2 random");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle_R6();
    t_add_R1();
    t_sub_R2();
    t_ovf_R3_R4();
    t_chain_R5();
    t_random_R1_R2();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule